// File: doc/BRIEF.md
# Chained Vector Arithmetic Unit

This block executes element-wise integer vector instructions over a small file of vector registers. Each register holds up to 64 elements of 32 bits. An add unit and a multiply unit each walk the elements of one instruction in index order and take one new element per clock. A length register sets how many leading elements each instruction touches. The length is taken when the instruction is accepted.

The two units can be busy at the same time. When one instruction reads a register that the other unit is still writing, the reader does not wait for the writer to finish. It follows the writer element by element. A per-element pending bit holds each read until the writer has stored that element, so the reader never sees old data. A small debug port reads any element of any register combinationally, so software-visible state can be inspected without disturbing execution.

Top module: `vchain_unit`

## Requirements
- R1: `iss_op` encodes the instruction: bit 0 selects the unit (0 = add, 1 = multiply) and bit 1 selects the form (0 = register-register, result[i] = A[i] op B[i]; 1 = scalar-register, result[i] = `iss_scalar` op B[i]). A is `iss_va`, B is `iss_vb` and the result goes to `iss_vd`.
- R2: Elements are 32-bit unsigned. Sums wrap modulo 2^32 and products keep the low 32 bits.
- R3: An instruction writes only elements 0 to VL-1 of its destination. Elements at index VL or above keep their previous values.
- R4: A write through `vl_we` sets VL to `vl_wdata`, saturated at 64. An instruction uses the VL held in the cycle it is accepted.
- R5: An instruction accepted with VL = 0 writes nothing, leaves its unit idle, and pulses its `done` bit in the cycle right after acceptance.
- R6: Each unit is fully pipelined, with 2 stages for add and 3 for multiply. An unhindered instruction of length n accepted at clock edge E pulses `done` for one cycle after edge E+n+D, where D is the unit's stage count.
- R7: A reader of a register that the other unit is writing chains on it. Reader element i enters its pipeline on the edge after the writer stores element i. The chained reader finishes strictly earlier than it could if it waited for the writer to finish.
- R8: Results always equal in-order sequential execution of the accepted instructions. This includes in-place updates where a source register is also the destination.
- R9: `iss_ready` is low while the selected unit is busy, while any element of the destination is still pending, or while the destination is a source of the other unit's running instruction. An instruction is accepted when `iss_valid` and `iss_ready` are both high.
- R10: After reset all registers and VL are zero, `busy` and `done` are low, and `iss_ready` is high.
- R11: `dbg_data` shows element `dbg_idx` of register `dbg_reg` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered |
| iss_op | input | 2 | Bit 0 selects the unit, bit 1 selects the scalar form |
| iss_vd | input | 3 | Destination register |
| iss_va | input | 3 | First source register (unused in scalar form) |
| iss_vb | input | 3 | Second source register |
| iss_scalar | input | 32 | Scalar operand |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| vl_we | input | 1 | Write the length register |
| vl_wdata | input | 7 | New length, saturated at 64 |
| busy | output | 1 | A unit is running an instruction |
| done | output | 2 | One-cycle completion pulse per unit (bit 0 add, bit 1 multiply) |
| dbg_reg | input | 3 | Debug register select |
| dbg_idx | input | 6 | Debug element select |
| dbg_data | output | 32 | Selected element |

## Verification
The bench predicts the edge on which every element is stored and every `done` pulse occurs. A design that read a chained source early would produce wrong products, and one that waited for the whole producer would pulse `done` late. Both show up as mismatches on the clock they occur.

Other corner cases are checked as well:
- VL = 0, to catch a unit that hangs or stores element 0 anyway.
- A length write of 100, to catch a missing saturation.
- A partial length of 10, to catch writes past VL.
- In-place updates, to catch a design that deadlocks on its own pending bits.
- Scalar operands that force wrap-around.

`iss_ready` is sampled against a busy unit, a pending destination and a destination that the other unit still reads. This catches an issue check that lets a write-after-read overwrite a live source.

// File: rtl/vcu_pkg.sv
`timescale 1ns/1ps
package vcu_pkg;

   localparam int unsigned VCU_FUS = 2;

   typedef enum logic [1:0] {
      OP_ADD_VV = 2'b00,
      OP_MUL_VV = 2'b01,
      OP_ADD_SV = 2'b10,
      OP_MUL_SV = 2'b11
   } vop_e;

   function automatic logic op_unit(input vop_e op);
      return op[0];
   endfunction

   function automatic logic op_scalar(input vop_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/vcu_lane.sv
`timescale 1ns/1ps
module vcu_lane #(
   parameter int unsigned W      = 32,
   parameter int unsigned NREG   = 8,
   parameter int unsigned MVL    = 64,
   parameter int unsigned STAGES = 2,
   parameter bit          IS_MUL = 1'b0,
   localparam int unsigned RW = $clog2(NREG),
   localparam int unsigned IW = $clog2(MVL),
   localparam int unsigned LW = $clog2(MVL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [RW-1:0] start_vd,
   input  logic [RW-1:0] start_va,
   input  logic [RW-1:0] start_vb,
   input  logic          start_sv,
   input  logic [W-1:0]  start_scal,
   input  logic [LW-1:0] start_vl,
   input  logic          pend_a,
   input  logic          pend_b,
   input  logic [W-1:0]  rd_a_data,
   input  logic [W-1:0]  rd_b_data,
   output logic          active,
   output logic          uses_a,
   output logic [RW-1:0] rd_a,
   output logic [RW-1:0] rd_b,
   output logic [IW-1:0] rd_idx,
   output logic [LW-1:0] cur_vl,
   output logic          elem_go,
   output logic          wb_valid,
   output logic [RW-1:0] wb_reg,
   output logic [IW-1:0] wb_idx,
   output logic [W-1:0]  wb_data,
   output logic          done
);

   if (STAGES < 1) begin : g_bad_stages
      $error("vcu_lane: STAGES must be at least 1");
   end

   logic          act_q, sv_q;
   logic [RW-1:0] vd_q, va_q, vb_q;
   logic [W-1:0]  scal_q;
   logic [LW-1:0] vl_q, idx_q;
   logic [W-1:0]  opa, res;
   logic          stall, last;

   logic          st_v [STAGES];
   logic [IW-1:0] st_i [STAGES];
   logic [W-1:0]  st_d [STAGES];

   // a source equal to the own destination is read before it is rewritten
   assign stall   = (pend_b && (vb_q != vd_q)) ||
                    (!sv_q && pend_a && (va_q != vd_q));
   assign elem_go = act_q && (idx_q < vl_q) && !stall;
   assign opa     = sv_q ? scal_q : rd_a_data;

   if (IS_MUL) begin : g_mul
      assign res = opa * rd_b_data;
   end else begin : g_add
      assign res = opa + rd_b_data;
   end

   assign last = st_v[STAGES-1] && (LW'(st_i[STAGES-1]) == vl_q - LW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_v[0] <= 1'b0;
         st_i[0] <= '0;
         st_d[0] <= '0;
      end else begin
         st_v[0] <= elem_go;
         st_i[0] <= idx_q[IW-1:0];
         st_d[0] <= res;
      end
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_v[k] <= 1'b0;
            st_i[k] <= '0;
            st_d[k] <= '0;
         end else begin
            st_v[k] <= st_v[k-1];
            st_i[k] <= st_i[k-1];
            st_d[k] <= st_d[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         sv_q   <= 1'b0;
         vd_q   <= '0;
         va_q   <= '0;
         vb_q   <= '0;
         scal_q <= '0;
         vl_q   <= '0;
         idx_q  <= '0;
         done   <= 1'b0;
      end else begin
         done <= (start && (start_vl == '0)) || (act_q && last);
         if (start) begin
            act_q  <= (start_vl != '0);
            sv_q   <= start_sv;
            vd_q   <= start_vd;
            va_q   <= start_va;
            vb_q   <= start_vb;
            scal_q <= start_scal;
            vl_q   <= start_vl;
            idx_q  <= '0;
         end else begin
            if (elem_go) idx_q <= idx_q + LW'(1);
            if (last)    act_q <= 1'b0;
         end
      end
   end

   assign active   = act_q;
   assign uses_a   = !sv_q;
   assign rd_a     = va_q;
   assign rd_b     = vb_q;
   assign rd_idx   = idx_q[IW-1:0];
   assign cur_vl   = vl_q;
   assign wb_valid = st_v[STAGES-1];
   assign wb_reg   = vd_q;
   assign wb_idx   = st_i[STAGES-1];
   assign wb_data  = st_d[STAGES-1];

endmodule

// File: rtl/vchain_unit.sv
`timescale 1ns/1ps
module vchain_unit #(
   parameter int unsigned W          = 32,
   parameter int unsigned NREG       = 8,
   parameter int unsigned MVL        = 64,
   parameter int unsigned ADD_STAGES = 2,
   parameter int unsigned MUL_STAGES = 3,
   localparam int unsigned RW  = $clog2(NREG),
   localparam int unsigned IW  = $clog2(MVL),
   localparam int unsigned LW  = $clog2(MVL + 1),
   localparam int unsigned FUS = vcu_pkg::VCU_FUS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          iss_valid,
   input  logic [1:0]    iss_op,
   input  logic [RW-1:0] iss_vd,
   input  logic [RW-1:0] iss_va,
   input  logic [RW-1:0] iss_vb,
   input  logic [W-1:0]  iss_scalar,
   output logic          iss_ready,
   input  logic          vl_we,
   input  logic [LW-1:0] vl_wdata,
   output logic          busy,
   output logic [FUS-1:0] done,
   input  logic [RW-1:0] dbg_reg,
   input  logic [IW-1:0] dbg_idx,
   output logic [W-1:0]  dbg_data
);
   import vcu_pkg::*;

   if ((1 << IW) != MVL) begin : g_bad_mvl
      $error("vchain_unit: MVL must be a power of two");
   end
   if ((1 << RW) != NREG) begin : g_bad_nreg
      $error("vchain_unit: NREG must be a power of two");
   end

   logic [W-1:0]   rf   [NREG][MVL];
   logic [MVL-1:0] pend [NREG];
   logic [MVL-1:0] pend_n [NREG];
   logic [LW-1:0]  vl_q;

   logic [FUS-1:0] lane_active, lane_uses_a, lane_go, lane_wb_valid, lane_done;
   logic [FUS-1:0] lane_start, lane_pa, lane_pb;
   logic [RW-1:0]  lane_rd_a [FUS];
   logic [RW-1:0]  lane_rd_b [FUS];
   logic [IW-1:0]  lane_rd_idx [FUS];
   logic [LW-1:0]  lane_vl [FUS];
   logic [RW-1:0]  lane_wb_reg [FUS];
   logic [IW-1:0]  lane_wb_idx [FUS];
   logic [W-1:0]   lane_wb_data [FUS];

   vop_e op;
   logic fu_sel, other, war, accept;

   assign op     = vop_e'(iss_op);
   assign fu_sel = op_unit(op);
   assign other  = !fu_sel;
   assign war    = lane_active[other] &&
                   ((lane_uses_a[other] && (lane_rd_a[other] == iss_vd)) ||
                    (lane_rd_b[other] == iss_vd));
   assign iss_ready = !lane_active[fu_sel] && (pend[iss_vd] == '0) && !war;
   assign accept    = iss_valid && iss_ready;

   for (genvar l = 0; l < FUS; l++) begin : g_lane
      localparam int unsigned STG = (l == 1) ? MUL_STAGES : ADD_STAGES;
      assign lane_start[l] = accept && (fu_sel == l[0]);
      assign lane_pa[l]    = pend[lane_rd_a[l]][lane_rd_idx[l]];
      assign lane_pb[l]    = pend[lane_rd_b[l]][lane_rd_idx[l]];

      vcu_lane #(
         .W(W), .NREG(NREG), .MVL(MVL), .STAGES(STG), .IS_MUL(l == 1)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (lane_start[l]),
         .start_vd   (iss_vd),
         .start_va   (iss_va),
         .start_vb   (iss_vb),
         .start_sv   (op_scalar(op)),
         .start_scal (iss_scalar),
         .start_vl   (vl_q),
         .pend_a     (lane_pa[l]),
         .pend_b     (lane_pb[l]),
         .rd_a_data  (rf[lane_rd_a[l]][lane_rd_idx[l]]),
         .rd_b_data  (rf[lane_rd_b[l]][lane_rd_idx[l]]),
         .active     (lane_active[l]),
         .uses_a     (lane_uses_a[l]),
         .rd_a       (lane_rd_a[l]),
         .rd_b       (lane_rd_b[l]),
         .rd_idx     (lane_rd_idx[l]),
         .cur_vl     (lane_vl[l]),
         .elem_go    (lane_go[l]),
         .wb_valid   (lane_wb_valid[l]),
         .wb_reg     (lane_wb_reg[l]),
         .wb_idx     (lane_wb_idx[l]),
         .wb_data    (lane_wb_data[l]),
         .done       (lane_done[l])
      );
   end

   always_comb begin
      for (int r = 0; r < NREG; r++) pend_n[r] = pend[r];
      for (int l = 0; l < FUS; l++)
         if (lane_wb_valid[l]) pend_n[lane_wb_reg[l]][lane_wb_idx[l]] = 1'b0;
      for (int i = 0; i < MVL; i++)
         if (accept && (LW'(i) < vl_q)) pend_n[iss_vd][i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vl_q <= '0;
         for (int r = 0; r < NREG; r++) pend[r] <= '0;
      end else begin
         if (vl_we) vl_q <= (vl_wdata > LW'(MVL)) ? LW'(MVL) : vl_wdata;
         for (int r = 0; r < NREG; r++) pend[r] <= pend_n[r];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++)
            for (int i = 0; i < MVL; i++) rf[r][i] <= '0;
      end else begin
         for (int l = 0; l < FUS; l++)
            if (lane_wb_valid[l]) rf[lane_wb_reg[l]][lane_wb_idx[l]] <= lane_wb_data[l];
      end
   end

   assign busy     = |lane_active;
   assign done     = lane_done;
   assign dbg_data = rf[dbg_reg][dbg_idx];

endmodule

// File: rtl/vchain_unit_chk.sv
`timescale 1ns/1ps
module vchain_unit_chk #(
   parameter int unsigned MVL = 64,
   parameter int unsigned FUS = 2,
   localparam int unsigned IW = $clog2(MVL),
   localparam int unsigned LW = $clog2(MVL + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           iss_valid,
   input logic           iss_ready,
   input logic [1:0]     iss_op,
   input logic           vl_we,
   input logic [LW-1:0]  vl_wdata,
   input logic [LW-1:0]  vl_q,
   input logic [FUS-1:0] done,
   input logic [FUS-1:0] lane_active,
   input logic [FUS-1:0] lane_wb_valid,
   input logic [IW-1:0]  lane_wb_idx [FUS],
   input logic [LW-1:0]  lane_vl [FUS]
);

   // R4: length register saturates at MVL
   a_r4_vl_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      vl_we |=> (vl_q == (($past(vl_wdata) > LW'(MVL)) ? LW'(MVL) : $past(vl_wdata))));

   a_r4_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
      vl_q <= LW'(MVL));

   for (genvar l = 0; l < FUS; l++) begin : g_chk
      // R5: zero-length instruction completes at once and leaves its unit idle
      a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid && iss_ready && (vl_q == '0) && (iss_op[0] == l[0]))
         |=> (done[l] && !lane_active[l]));

      // R3: no store at or beyond the instruction's length
      a_r3_wb_in_range: assert property (@(posedge clk) disable iff (!rst_n)
         lane_wb_valid[l] |-> (LW'(lane_wb_idx[l]) < lane_vl[l]));

      // R9: a unit only becomes busy through an accepted instruction
      a_r9_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lane_active[l]) |-> $past(iss_valid && iss_ready && (iss_op[0] == l[0])));

      // R6: the completion pulse leaves the unit idle
      a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
         done[l] |-> !lane_active[l]);
   end

endmodule

bind vchain_unit vchain_unit_chk #(.MVL(MVL), .FUS(FUS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .iss_valid     (iss_valid),
   .iss_ready     (iss_ready),
   .iss_op        (iss_op),
   .vl_we         (vl_we),
   .vl_wdata      (vl_wdata),
   .vl_q          (vl_q),
   .done          (done),
   .lane_active   (lane_active),
   .lane_wb_valid (lane_wb_valid),
   .lane_wb_idx   (lane_wb_idx),
   .lane_vl       (lane_vl)
);

// File: tb/sim_vchain_unit.sv
`timescale 1ns/1ps
module sim_vchain_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic [1:0]  iss_op = '0;
   logic [2:0]  iss_vd = '0, iss_va = '0, iss_vb = '0;
   logic [31:0] iss_scalar = '0;
   logic        iss_ready;
   logic        vl_we = 1'b0;
   logic [6:0]  vl_wdata = '0;
   logic        busy;
   logic [1:0]  done;
   logic [2:0]  dbg_reg = '0;
   logic [5:0]  dbg_idx = '0;
   logic [31:0] dbg_data;

   always #10 clk = ~clk;

   vchain_unit u0 (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_vd(iss_vd), .iss_va(iss_va), .iss_vb(iss_vb), .iss_scalar(iss_scalar),
      .iss_ready(iss_ready), .vl_we(vl_we), .vl_wdata(vl_wdata), .busy(busy),
      .done(done), .dbg_reg(dbg_reg), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
   );

   int errors = 0, checks = 0;
   int cyc = 0;
   bit monitor_on = 1'b0;
   bit finished = 1'b0;

   logic [31:0] mrf [8][64];
   int          rdy [8][64];
   int          mvl = 0;
   int          next_done [2] = '{-1, -1};

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // R6 R7: per-clock comparison of completion pulses against the model
   always @(negedge clk) begin
      if (monitor_on) begin
         for (int k = 0; k < 2; k++) begin
            bit exp_d;
            exp_d = (next_done[k] == cyc);
            chk(done[k] == exp_d, k ? "R6/R7 mul done" : "R6/R7 add done", done[k], exp_d);
            if (exp_d) next_done[k] = -1;
         end
      end
   end

   task automatic set_vl(input int v);
      @(negedge clk);
      vl_we = 1'b1;
      vl_wdata = v[6:0];
      @(posedge clk);
      #1 vl_we = 1'b0;
      mvl = (v > 64) ? 64 : v;
   endtask

   task automatic issue(input int op, input int vd, input int va, input int vb,
                        input logic [31:0] sc, output int done_edge);
      int e, prev, st, w, d;
      bit sv, mul;
      logic [31:0] a, b;
      @(negedge clk);
      iss_valid = 1'b1;
      iss_op = op[1:0];
      iss_vd = vd[2:0];
      iss_va = va[2:0];
      iss_vb = vb[2:0];
      iss_scalar = sc;
      #1;
      while (!iss_ready) begin
         @(negedge clk);
         #1;
      end
      e = cyc + 1;
      mul = op[0];
      sv = op[1];
      d = mul ? 3 : 2;
      prev = e;
      done_edge = e;
      for (int i = 0; i < mvl; i++) begin
         st = prev + 1;
         if (!sv && va != vd && rdy[va][i] + 1 > st) st = rdy[va][i] + 1;
         if (vb != vd && rdy[vb][i] + 1 > st) st = rdy[vb][i] + 1;
         w = st + d;
         prev = st;
         a = sv ? sc : mrf[va][i];
         b = mrf[vb][i];
         mrf[vd][i] = mul ? a * b : a + b;
         rdy[vd][i] = w;
         done_edge = w;
      end
      next_done[mul] = done_edge;
      @(posedge clk);
      #1 iss_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (next_done[0] != -1 || next_done[1] != -1 || busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic compare_all(input string req);
      for (int r = 0; r < 8; r++)
         for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            dbg_reg = r[2:0];
            dbg_idx = i[5:0];
            #1 chk(dbg_data == mrf[r][i], req, dbg_data, mrf[r][i]);
         end
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int de, dm, da;
      for (int r = 0; r < 8; r++)
         for (int i = 0; i < 64; i++) begin
            mrf[r][i] = '0;
            rdy[r][i] = 0;
         end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10: reset state
      @(negedge clk);
      dbg_reg = 3'd3;
      dbg_idx = 6'd5;
      #1;
      chk(busy == 1'b0, "R10 busy", busy, 0);
      chk(done == 2'b00, "R10 done", done, 0);
      chk(iss_ready == 1'b1, "R10 ready", iss_ready, 1);
      chk(dbg_data == 32'd0, "R10 R11 register zero", dbg_data, 0);
      monitor_on = 1'b1;

      // R5: VL is zero out of reset, so this writes nothing
      issue(0, 2, 0, 0, 32'd0, de);

      // R4: saturating length write, then fill v1 with 7 (R1 scalar add)
      set_vl(100);
      issue(2, 1, 0, 0, 32'd7, de);
      wait_idle();

      // R8: in-place ramp, v1 = 1 + v1 with shrinking VL (R3)
      for (int k = 64; k >= 1; k -= 9) begin
         set_vl(k);
         issue(2, 1, 0, 1, 32'd1, de);
      end
      wait_idle();
      compare_all("R3 R8 ramp");

      // R5: zero length from a register write
      set_vl(0);
      issue(0, 2, 1, 1, 32'd0, de);
      issue(1, 3, 1, 1, 32'd0, de);
      wait_idle();

      // R7: multiply producer, add consumer chained on v3
      set_vl(64);
      issue(1, 3, 1, 1, 32'd0, dm);
      issue(0, 4, 3, 1, 32'd0, da);
      chk(da < dm + 64 + 2, "R7 chained completion earlier", da, dm + 64 + 2);
      wait_idle();

      // R2: wrap-around with scalar forms
      issue(3, 5, 0, 3, 32'h0001_0001, de);
      issue(2, 6, 0, 1, 32'hFFFF_FFF0, de);
      wait_idle();

      // R3: partial length leaves upper elements
      set_vl(10);
      issue(3, 3, 0, 1, 32'd3, de);
      wait_idle();
      compare_all("R2 R3 R7 data");

      // R9: ready under structural and register hazards
      set_vl(64);
      issue(3, 7, 0, 1, 32'd2, de);
      @(negedge clk);
      iss_op = 2'd0; iss_vd = 3'd1; iss_va = 3'd2; iss_vb = 3'd2;
      #1 chk(iss_ready == 1'b0, "R9 WAR on live source", iss_ready, 0);
      iss_vd = 3'd7;
      #1 chk(iss_ready == 1'b0, "R9 pending destination", iss_ready, 0);
      iss_op = 2'd1; iss_vd = 3'd6;
      #1 chk(iss_ready == 1'b0, "R9 busy unit", iss_ready, 0);
      iss_op = 2'd0; iss_vd = 3'd6; iss_va = 3'd7;
      #1 chk(iss_ready == 1'b1, "R9 free chained reader", iss_ready, 1);
      wait_idle();

      // R7: add producer, multiply consumer
      set_vl(40);
      issue(2, 2, 0, 1, 32'd5, dm);
      issue(1, 0, 2, 3, 32'd0, da);
      wait_idle();
      compare_all("R1 R8 final");

      monitor_on = 1'b0;
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule